// File: doc/BRIEF.md
# Hot-plug I/O expander manager

This block keeps the hot-plug control outputs and status inputs of several downstream ports in step with a set of external I/O expanders that sit on the shared management (SMBus master) bus. Each expander `k` owns one `DW`-bit slice of the hot-plug output vector and one `DW`-bit slice of the hot-plug input vector. It also has its own active-low interrupt line. The block does not drive the serial bus itself. It places one whole-byte transaction at a time on an abstract request interface: kind, address, data, and a done/ok/response return. A separate master bus engine carries out the transaction.

The block stays silent until `cfg_done` is high. Before that point, the record of the last written value simply follows the output vector. After configuration, whenever an expander's output slice differs from the value last written to it, the block writes the complete slice to that expander. While an expander's interrupt is low, the block reads that expander's complete input slice. It stores the result and flags the slice as changed if the new value differs from the old one. Only one request is outstanding at a time. Pending writes take precedence over reads.

The control is a three-state machine:
- IDLE: picks the next job. The transition *launch* (IDLE→BUSY) is taken when any write or read is pending.
- BUSY: holds the request on the interface. The transition *finish* (BUSY→GAP) is taken on `req_done`.
- GAP: a single quiet cycle that separates transaction slots. The transition *rearm* (GAP→IDLE) is taken unconditionally.

Top module: `hp_expander_mgr`

## Requirements
- R1: After reset `req_valid`, `hp_in` and `hp_in_chg` are 0. While `cfg_done` is 0 no request is raised, whatever `hp_out` and `exp_int_n` do. Output values set before `cfg_done` rises cause no write afterwards.
- R2: With `cfg_done` high, a change of slice `k` (bits `[k*DW +: DW]`) of `hp_out` produces one write request. A write has `req_read`=0, `req_addr` = `BASE_ADDR`+`k`, and `req_data` equal to the whole current slice.
- R3: If a slice changes again while a transaction is in flight, exactly one further write follows, and it carries the latest value. If the slice returns to the value being written before that write completes, no further write is issued.
- R4: A write that completes with `req_ok`=0 is issued again with the slice's current value.
- R5: With `cfg_done` high, a low level on `exp_int_n[k]` produces a read request. A read has `req_read`=1 and `req_addr` = `BASE_ADDR`+`k`. The interrupt passes through a two-flop synchronizer first.
- R6: While `req_valid` is high and `req_done` is low, `req_valid`, `req_read`, `req_addr` and `req_data` hold their values. After the cycle in which `req_done` is high, `req_valid` stays low for at least two cycles.
- R7: When several jobs are pending in IDLE, every write goes before any read. Among jobs of the same kind, the lowest expander index goes first.
- R8: If `exp_int_n[k]` is still low when a read of expander `k` completes, another read of expander `k` is issued.
- R9: Slice `k` of `hp_in` changes only in the cycle after a read of expander `k` completes with `req_ok`=1. It then takes the value of `rsp_data`. A failed read leaves it unchanged.
- R10: `hp_in_chg[k]` is high for exactly the one cycle in which slice `k` of `hp_in` has just been updated, and only if the new value differs from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | High once reset-time configuration has finished |
| hp_out | input | N_EXP*DW | Hot-plug output vector, slice k belongs to expander k |
| exp_int_n | input | N_EXP | Active-low interrupt from each expander (asynchronous) |
| req_valid | output | 1 | A transaction request is presented |
| req_read | output | 1 | 1 = read, 0 = write |
| req_addr | output | ADDR_W | Bus address of the target expander |
| req_data | output | DW | Data to write |
| req_done | input | 1 | The bus engine has finished the current request |
| req_ok | input | 1 | The finished request was acknowledged (valid with req_done) |
| rsp_data | input | DW | Read data (valid with req_done) |
| hp_in | output | N_EXP*DW | Registered hot-plug input vector |
| hp_in_chg | output | N_EXP | One-cycle flag per slice: the last read changed it |

## Verification
Several input patterns are used, and each separates a different weakness:

- A single output change checks the address and the whole-slice data.
- Bursts of changes during a write in flight show whether the block sends the latest value exactly once, rather than every intermediate value or a stale one.
- A change followed by a change back tells a compare against the value last written apart from a compare against the previous cycle's input.
- Failed acknowledgements on a write and on a read separate retry from silent loss, and show that `hp_in` is held.
- Interrupts that are released, or kept low, at completion separate level-sensitive behaviour from edge-sensitive behaviour.
- Writes and reads on several expanders raised while one transaction is busy expose the order of arbitration.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP  = 2'd2
    } hpx_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
    parameter int W        = 1,
    parameter int STAGES   = 2,
    parameter bit RST_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= {W{RST_HIGH}};
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/hpx_pick.sv
module hpx_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/hp_expander_mgr.sv
module hp_expander_mgr
    import hpx_pkg::*;
#(
    parameter int N_EXP     = 3,
    parameter int DW        = 8,
    parameter int ADDR_W    = 7,
    parameter int BASE_ADDR = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_done,
    input  logic [N_EXP*DW-1:0]   hp_out,
    input  logic [N_EXP-1:0]      exp_int_n,
    output logic                  req_valid,
    output logic                  req_read,
    output logic [ADDR_W-1:0]     req_addr,
    output logic [DW-1:0]         req_data,
    input  logic                  req_done,
    input  logic                  req_ok,
    input  logic [DW-1:0]         rsp_data,
    output logic [N_EXP*DW-1:0]   hp_in,
    output logic [N_EXP-1:0]      hp_in_chg
);

    localparam int IDX_W = idx_width(N_EXP);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);

    hpx_state_e         state_q, state_d;
    logic [N_EXP-1:0]   int_n_s;
    logic [N_EXP-1:0]   wr_pend, rd_pend;
    logic               wr_any, rd_any;
    logic [IDX_W-1:0]   wr_idx, rd_idx;
    logic [DW-1:0]      wr_data;
    logic               launch, done_ev;
    logic               cur_read_q;
    logic [IDX_W-1:0]   cur_idx_q;
    logic [DW-1:0]      cur_data_q;
    logic [DW-1:0]      sent_q [N_EXP];
    logic [DW-1:0]      in_q   [N_EXP];
    logic [N_EXP-1:0]   chg_q;

    // interrupt lines are asynchronous: two flops, idle-high reset
    hpx_sync #(.W(N_EXP), .STAGES(2), .RST_HIGH(1'b1)) u_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (exp_int_n),
        .q     (int_n_s)
    );

    assign rd_pend = {N_EXP{cfg_done}} & ~int_n_s;

    hpx_pick #(.N(N_EXP), .IW(IDX_W)) u_pick_wr (
        .req (wr_pend),
        .any (wr_any),
        .idx (wr_idx)
    );

    hpx_pick #(.N(N_EXP), .IW(IDX_W)) u_pick_rd (
        .req (rd_pend),
        .any (rd_any),
        .idx (rd_idx)
    );

    always_comb begin
        wr_data = '0;
        for (int k = 0; k < N_EXP; k++) begin
            if (wr_idx == IDX_W'(k)) wr_data = hp_out[k*DW +: DW];
        end
    end

    assign launch  = (state_q == ST_IDLE) && (wr_any || rd_any);
    assign done_ev = (state_q == ST_BUSY) && req_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_d = ST_BUSY;   // launch
            ST_BUSY: if (req_done) state_d = ST_GAP;    // finish
            ST_GAP:                state_d = ST_IDLE;   // rearm
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_BUSY);
        req_read  = cur_read_q;
        req_addr  = BASE_A + ADDR_W'(cur_idx_q);
        req_data  = cur_data_q;
    end

    // job capture at launch: writes win over reads (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_read_q <= 1'b0;
            cur_idx_q  <= '0;
            cur_data_q <= '0;
        end else if (launch) begin
            cur_read_q <= !wr_any;
            cur_idx_q  <= wr_any ? wr_idx : rd_idx;
            cur_data_q <= wr_any ? wr_data : '0;
        end
    end

    for (genvar k = 0; k < N_EXP; k++) begin : g_slice
        logic hit;
        assign hit = done_ev && req_ok && (cur_idx_q == IDX_W'(k));

        // last value acknowledged by expander k; shadows hp_out before config
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   sent_q[k] <= '0;
            else if (!cfg_done)           sent_q[k] <= hp_out[k*DW +: DW];
            else if (hit && !cur_read_q)  sent_q[k] <= cur_data_q;
        end

        assign wr_pend[k] = cfg_done && (hp_out[k*DW +: DW] != sent_q[k]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[k]  <= '0;
                chg_q[k] <= 1'b0;
            end else begin
                chg_q[k] <= hit && cur_read_q && (rsp_data != in_q[k]);
                if (hit && cur_read_q) in_q[k] <= rsp_data;
            end
        end

        assign hp_in[k*DW +: DW] = in_q[k];
    end

    assign hp_in_chg = chg_q;

endmodule

// File: rtl/hpx_checks.sv
module hpx_checks #(
    parameter int N_EXP     = 3,
    parameter int DW        = 8,
    parameter int ADDR_W    = 7,
    parameter int BASE_ADDR = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_done,
    input logic                req_valid,
    input logic                req_read,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DW-1:0]       req_data,
    input logic                req_done,
    input logic                req_ok,
    input logic [N_EXP*DW-1:0] hp_in,
    input logic [N_EXP-1:0]    hp_in_chg
);

    // R1: nothing is started while configuration is unfinished
    a_r1_quiet_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !cfg_done) |=> !req_valid);

    // R2, R5: the address always names one of the expanders
    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((int'(req_addr) >= BASE_ADDR) && (int'(req_addr) < BASE_ADDR + N_EXP)));

    // R6: request fields hold until completion
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done) |=> (req_valid && $stable(req_read)
                                      && $stable(req_addr) && $stable(req_data)));

    // R6: two quiet cycles separate transaction slots
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_done) |=> !req_valid ##1 !req_valid);

    // R9: input vector moves only after a successful read
    a_r9_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_done && req_read && req_ok) |=> $stable(hp_in));

    // R10: a change flag follows a successful read
    a_r10_chg_src: assert property (@(posedge clk) disable iff (!rst_n)
        (|hp_in_chg) |-> $past(req_valid && req_done && req_read && req_ok));

    // R10: at most one slice flagged at a time
    a_r10_chg_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hp_in_chg));

endmodule

bind hp_expander_mgr hpx_checks #(
    .N_EXP     (N_EXP),
    .DW        (DW),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_hpx_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_done  (req_done),
    .req_ok    (req_ok),
    .hp_in     (hp_in),
    .hp_in_chg (hp_in_chg)
);

// File: tb/test_hp_expander_mgr.sv
module test_hp_expander_mgr;

    localparam int N    = 3;
    localparam int DW   = 8;
    localparam int BASE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_done = 1'b0;
    logic [N*DW-1:0] hp_out = '0;
    logic [N-1:0]  exp_int_n = '1;
    logic          req_valid, req_read;
    logic [6:0]    req_addr;
    logic [DW-1:0] req_data;
    logic          req_done = 1'b0;
    logic          req_ok = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic [N*DW-1:0] hp_in;
    logic [N-1:0]  hp_in_chg;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    hp_expander_mgr #(.N_EXP(N), .DW(DW), .ADDR_W(7), .BASE_ADDR(BASE)) i_hp_expander_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .hp_out(hp_out),
        .exp_int_n(exp_int_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_data(req_data), .req_done(req_done),
        .req_ok(req_ok), .rsp_data(rsp_data), .hp_in(hp_in), .hp_in_chg(hp_in_chg)
    );

    task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_slice(int k, logic [DW-1:0] v);
        hp_out[k*DW +: DW] = v;
    endtask

    task automatic quiet(string tag, int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen++;
        end
        chk_eq(tag, seen, 0);
    endtask

    // one bus transaction as the master engine would answer it
    task automatic serve(string tag, bit rd, int k, logic [DW-1:0] wdata,
                         logic [DW-1:0] rdata, bit ok, bit rel, int dly);
        int t = 0;
        int bad = 0;
        logic [DW-1:0] d0;
        while (!req_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk_eq({tag, " valid"}, req_valid, 1);
        chk_eq({tag, " kind"}, req_read, rd);
        chk_eq({tag, " addr"}, req_addr, BASE + k);
        if (!rd) chk_eq({tag, " data"}, req_data, wdata);
        d0 = req_data;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (!req_valid || req_read !== rd || req_addr !== 7'(BASE + k) || req_data !== d0) bad++;
        end
        if (dly > 0) chk_eq({tag, " R6 hold"}, bad, 0);
        req_done = 1'b1;
        req_ok   = ok;
        rsp_data = rdata;
        if (rel) exp_int_n[k] = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
        req_ok   = 1'b0;
        rsp_data = '0;
        chk_eq({tag, " R6 gap"}, req_valid, 0);
        @(negedge clk);
        chk_eq({tag, " R6 gap2"}, req_valid, 0);
    endtask

    // note: serve returns one cycle after the update; chg checks use a separate path
    task automatic serve_rd(string tag, int k, logic [DW-1:0] rdata, bit ok, bit rel,
                            logic [DW-1:0] exp_in, logic [N-1:0] exp_chg);
        int t = 0;
        while (!req_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk_eq({tag, " valid"}, req_valid, 1);
        chk_eq({tag, " kind"}, req_read, 1);
        chk_eq({tag, " addr"}, req_addr, BASE + k);
        req_done = 1'b1;
        req_ok   = ok;
        rsp_data = rdata;
        if (rel) exp_int_n[k] = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
        req_ok   = 1'b0;
        rsp_data = '0;
        chk_eq({tag, " R9 hp_in"}, hp_in[k*DW +: DW], exp_in);
        chk_eq({tag, " R10 chg"}, hp_in_chg, exp_chg);
        @(negedge clk);
        chk_eq({tag, " R10 chg clears"}, hp_in_chg, 0);
    endtask

    task automatic t_reset();
        chk_eq("R1 reset req_valid", req_valid, 0);
        chk_eq("R1 reset hp_in", hp_in, 0);
        chk_eq("R1 reset hp_in_chg", hp_in_chg, 0);
    endtask

    task automatic t_precfg();
        hp_out = 24'h123456;
        exp_int_n[0] = 1'b0;
        quiet("R1 no request before cfg_done", 12);
        exp_int_n[0] = 1'b1;
        repeat (3) @(negedge clk);
        cfg_done = 1'b1;
        quiet("R1 no write for pre-config value", 12);
    endtask

    task automatic t_write();
        set_slice(1, 8'hA5);
        serve("R2 write slice1", 0, 1, 8'hA5, 8'h00, 1, 0, 0);
        quiet("R3 single write", 8);
    endtask

    task automatic t_coalesce();
        set_slice(0, 8'h11);
        @(negedge clk);
        @(negedge clk);
        chk_eq("R3 first write launched", req_valid, 1);
        set_slice(0, 8'h22);
        @(negedge clk);
        set_slice(0, 8'h33);
        serve("R3 first write", 0, 0, 8'h11, 8'h00, 1, 0, 2);
        serve("R3 latest value", 0, 0, 8'h33, 8'h00, 1, 0, 0);
        quiet("R3 exactly one follow-up", 8);
        set_slice(0, 8'h44);
        @(negedge clk);
        @(negedge clk);
        set_slice(0, 8'h55);
        @(negedge clk);
        set_slice(0, 8'h44);
        serve("R3 restore write", 0, 0, 8'h44, 8'h00, 1, 0, 1);
        quiet("R3 no write when value restored", 8);
    endtask

    task automatic t_retry();
        set_slice(2, 8'h7E);
        serve("R4 failed write", 0, 2, 8'h7E, 8'h00, 0, 0, 0);
        serve("R4 retried write", 0, 2, 8'h7E, 8'h00, 1, 0, 0);
        quiet("R4 no write after success", 8);
    endtask

    task automatic t_read();
        exp_int_n[1] = 1'b0;
        serve_rd("R5 read exp1", 1, 8'h5A, 1, 1, 8'h5A, 3'b010);
        quiet("R8 no reread after release", 8);
        exp_int_n[1] = 1'b0;
        serve_rd("R10 same value read", 1, 8'h5A, 1, 1, 8'h5A, 3'b000);
        quiet("R8 idle after second read", 6);
    endtask

    task automatic t_read_fail();
        exp_int_n[2] = 1'b0;
        serve_rd("R9 failed read", 2, 8'hFF, 0, 0, 8'h00, 3'b000);
        serve_rd("R8 reread while low", 2, 8'hC3, 1, 1, 8'hC3, 3'b100);
        quiet("R8 quiet after exp2 release", 6);
    endtask

    task automatic t_level();
        exp_int_n[0] = 1'b0;
        serve_rd("R8 level first", 0, 8'h0F, 1, 0, 8'h0F, 3'b001);
        serve_rd("R8 level again", 0, 8'hF0, 1, 1, 8'hF0, 3'b001);
        quiet("R8 stops after release", 6);
    endtask

    task automatic t_priority();
        set_slice(0, 8'h66);
        @(negedge clk);
        @(negedge clk);
        chk_eq("R7 busy before mix", req_valid, 1);
        set_slice(1, 8'h77);
        set_slice(2, 8'h88);
        exp_int_n[2] = 1'b0;
        exp_int_n[0] = 1'b0;
        serve("R7 write exp0", 0, 0, 8'h66, 8'h00, 1, 0, 4);
        serve("R7 write exp1 next", 0, 1, 8'h77, 8'h00, 1, 0, 0);
        serve("R7 write exp2 next", 0, 2, 8'h88, 8'h00, 1, 0, 0);
        serve_rd("R7 read exp0 after writes", 0, 8'h01, 1, 1, 8'h01, 3'b001);
        serve_rd("R7 read exp2 last", 2, 8'h02, 1, 1, 8'h02, 3'b100);
        quiet("R7 all jobs drained", 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_precfg();
        t_write();
        t_coalesce();
        t_retry();
        t_read();
        t_read_fail();
        t_level();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule